// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital core of an 8-bit successive-approximation converter that sits on a processor bus. A processor starts a conversion with active-low chip-select and write strobes. The block then walks a trial code from the most significant bit down, driving an external DAC and reading back a single comparator bit. When the last bit is settled, the final code goes into an output latch and an active-low interrupt is raised. A read strobe, qualified by chip select, clears the interrupt and enables the data bus. The bus is tri-statable and is modelled here as a data word plus an output-enable flag.

The start is level-sensitive. While chip select and write are both low, the sequencer is held cleared. Conversion begins only after the strobe is released, and it is aligned to the next boundary of a free-running step timer. Issuing a new start while a conversion is running abandons that conversion and begins again. If the interrupt output is fed back to the write input with chip select held low, the block converts continuously. Each step lasts a fixed number of clocks. All three strobes pass through two-flop synchronizers before use.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset, irq_n is 1, data_oe is 0, data_out is 0x00 and trial_code is 0x00.
- R2: While cs_n and wr_n are both sampled low, trial_code stays 0x00 and irq_n is held 1, even when an unread result was pending.
- R3: After the start strobe is released, irq_n falls 66 to 73 clock periods after the first rising edge that samples the release. The spread comes from alignment to the step timer.
- R4: Conversion starts with trial_code = 0x80. Each bit step lasts STEP_CLKS (8) clocks and the bits are tested from MSB to LSB. A bit is kept when cmp_hi = 1 (input at or above the trial value) and cleared otherwise.
- R5: With an ideal comparator (cmp_hi = input >= trial_code), the latched result equals the input for every code. Full scale gives 0xFF, and an input that never reaches a trial level gives 0x00.
- R6: data_out holds the previous result, unchanged, until the next conversion completes.
- R7: While cs_n and rd_n are both low, data_oe is 1. The start of such a read raises irq_n.
- R8: A start strobe during a running conversion abandons it. No interrupt follows from the abandoned run, and the new conversion's result and timing obey R3 and R5.
- R9: When a completion and an active read fall in the same cycle, the completion wins: irq_n goes low and stays low until a new read strobe begins.
- R10: With wr_n tied to irq_n and cs_n low, conversions repeat with no further stimulus once one explicit write pulse is given. Without that pulse, nothing starts after reset.
- R11: A read strobe with cs_n high leaves data_oe at 0 and does not clear a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Start strobe, active low, asynchronous |
| rd_n | input | 1 | Output enable strobe, active low, asynchronous |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| trial_code | output | 8 | Trial code driving the external DAC |
| irq_n | output | 1 | Conversion-complete interrupt, active low |
| data_out | output | 8 | Output latch contents, the bus value when enabled |
| data_oe | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
Completion of the last bit step and the start of a read can both change the interrupt in the same clock. To provoke the overlap, the bench holds chip select and read low through an entire conversion, so the read is active on the very cycle the result lands. It then checks that the interrupt falls and stays low, and that a fresh read strobe clears it. A second overlap is between a new start and a running conversion. The bench judges it by the absence of an interrupt from the abandoned run and by the code and latency of the restarted one.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned DEF_BITS        = 8;
  localparam int unsigned DEF_STEP_CLKS   = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic logic [DEF_BITS-1:0] msb_onehot();
    msb_onehot = {1'b1, {(DEF_BITS-1){1'b0}}};
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_phase.sv
module sar_phase #(
  parameter int unsigned STEP_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(STEP_CLKS - 1);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else if (ph == LAST) ph <= '0;
    else ph <= ph + 1'b1;
  end

  assign tick = (ph == LAST);
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            tick,
  input  logic            cmp_hi,
  output logic [BITS-1:0] trial,
  output logic            done,
  output logic [BITS-1:0] result
);
  localparam logic [BITS-1:0] MSB = {1'b1, {(BITS-1){1'b0}}};

  logic            armed;
  logic [BITS-1:0] token;
  logic [BITS-1:0] sar_next;

  always_comb sar_next = cmp_hi ? trial : (trial & ~token);

  assign done   = tick & token[0] & ~hold;
  assign result = sar_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      token <= '0;
      trial <= '0;
    end else if (hold) begin
      armed <= 1'b1;
      token <= '0;
      trial <= '0;
    end else if (tick) begin
      if (armed) begin
        armed <= 1'b0;
        token <= MSB;
        trial <= MSB;
      end else if (token != '0) begin
        token <= token >> 1;
        trial <= sar_next | (token >> 1);
      end
    end
  end

  // R2: a held start clears the sequencer
  assert_hold_clears_R2: assert property (@(posedge clk) disable iff (rst)
    hold |=> (trial == '0 && token == '0));
  // R4: a single token walks the stages
  assert_token_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(token));
  // R4: MSB is the first trial
  assert_msb_first_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && tick && !hold) |=> (trial == MSB));
  // R4: a step only advances on the step boundary
  assert_step_len_R4: assert property (@(posedge clk) disable iff (rst)
    (token != '0 && !tick && !hold) |=> $stable(token));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned BITS        = sar_pkg::DEF_BITS,
  parameter int unsigned STEP_CLKS   = sar_pkg::DEF_STEP_CLKS,
  parameter int unsigned SYNC_STAGES = sar_pkg::DEF_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic            cmp_hi,
  output logic [BITS-1:0] trial_code,
  output logic            irq_n,
  output logic [BITS-1:0] data_out,
  output logic            data_oe
);
  logic [2:0]      strb_s;
  logic            cs_s, wr_s, rd_s;
  logic            hold, rd_act, rd_q, rd_rise;
  logic            tick, done;
  logic [BITS-1:0] result;

  sar_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, wr_n, rd_n}), .q(strb_s)
  );
  assign {cs_s, wr_s, rd_s} = strb_s;

  assign hold    = ~cs_s & ~wr_s;
  assign rd_act  = ~cs_s & ~rd_s;
  assign rd_rise = rd_act & ~rd_q;

  sar_phase #(.STEP_CLKS(STEP_CLKS)) u_phase (
    .clk(clk), .rst(rst), .tick(tick)
  );

  sar_core #(.BITS(BITS)) u_core (
    .clk(clk), .rst(rst), .hold(hold), .tick(tick), .cmp_hi(cmp_hi),
    .trial(trial_code), .done(done), .result(result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n    <= 1'b1;
      data_out <= '0;
      data_oe  <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      rd_q    <= rd_act;
      data_oe <= rd_act;
      if (hold) begin
        irq_n <= 1'b1;
      end else if (done) begin
        irq_n    <= 1'b0;
        data_out <= result;
      end else if (rd_rise) begin
        irq_n <= 1'b1;
      end
    end
  end

  // R2: start level forces the interrupt inactive
  assert_start_irq_R2: assert property (@(posedge clk) disable iff (rst)
    hold |=> irq_n);
  // R5: interrupt only falls on a completed conversion
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(done));
  // R6: latch holds between completions
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(data_out));
  // R7: qualified read enables the bus
  assert_oe_follow_R7: assert property (@(posedge clk) disable iff (rst)
    rd_act |=> data_oe);
  // R9: completion outranks a concurrent read
  assert_done_wins_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !irq_n);
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1, fr = 1'b0;
  logic [7:0] vin = 8'h00;
  logic       wr_n, cmp_hi, irq_n, data_oe;
  logic [7:0] trial_code, data_out;
  int         n_chk = 0, n_err = 0;
  bit         wd_hit = 1'b0;

  always #5 clk = ~clk;

  assign wr_n   = fr ? (irq_n & wr_drv) : wr_drv;
  assign cmp_hi = (vin >= trial_code);

  sar_conv_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cmp_hi(cmp_hi), .trial_code(trial_code), .irq_n(irq_n),
    .data_out(data_out), .data_oe(data_oe)
  );

  localparam int NV = 9;
  localparam logic [7:0] VEC_IN  [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE, 8'h55, 8'hAA, 8'h3C};
  localparam logic [7:0] VEC_EXP [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE, 8'h55, 8'hAA, 8'h3C};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_conv(input logic [7:0] v);
    @(negedge clk);
    vin = v; cs_n = 1'b0; wr_drv = 1'b0;
    repeat (4) @(negedge clk);
    wr_drv = 1'b1;
  endtask

  task automatic wait_irq(output int lat);
    lat = 0;
    while (lat < 200) begin
      @(posedge clk);
      lat++;
      #1;
      if (!irq_n) break;
    end
  endtask

  task automatic read_back(output logic [7:0] got, output logic oe, output logic irq_after);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    got = data_out; oe = data_oe; irq_after = irq_n;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int lat, falls;
    logic [7:0] got;
    logic oe, irq_a;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq_n == 1'b1 && data_oe == 1'b0 && data_out == 8'h00 && trial_code == 8'h00,
        "R1 reset", {irq_n, data_oe, data_out, trial_code}, 18'h20000);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R3 R4 R5 R7 table of stimulus and expected codes
    for (int i = 0; i < NV; i++) begin
      start_conv(VEC_IN[i]);
      wait_irq(lat);
      chk(lat - 1 >= 66 && lat - 1 <= 73, "R3 latency", lat - 1, 70);
      read_back(got, oe, irq_a);
      chk(got == VEC_EXP[i], "R5 table code", got, VEC_EXP[i]);
      chk(oe == 1'b1, "R7 data_oe during read", oe, 1);
      chk(irq_a == 1'b1, "R7 read clears irq_n", irq_a, 1);
    end
    chk(data_oe == 1'b0, "R7 bus released", data_oe, 0);

    // R4 first trial is MSB, step length 8
    start_conv(8'h40);
    begin
      int seen = 0;
      while (seen < 20 && trial_code == 8'h00) begin @(negedge clk); seen++; end
      chk(trial_code == 8'h80, "R4 first trial MSB", trial_code, 8'h80);
      repeat (7) @(negedge clk);
      chk(trial_code == 8'h80, "R4 step lasts 8 clocks", trial_code, 8'h80);
      @(negedge clk);
      chk(trial_code == 8'h40, "R4 bit7 cleared, bit6 tried", trial_code, 8'h40);
      repeat (8) @(negedge clk);
      chk(trial_code == 8'h60, "R4 bit6 kept, bit5 tried", trial_code, 8'h60);
    end
    wait_irq(lat);

    // R11 read without chip select, irq pending
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(data_oe == 1'b0, "R11 no oe without cs", data_oe, 0);
    chk(irq_n == 1'b0, "R11 irq_n still pending", irq_n, 0);
    rd_n = 1'b1;

    // R2 start held low forces irq_n high and clears trial
    @(negedge clk); vin = 8'hC3; cs_n = 1'b0; wr_drv = 1'b0;
    repeat (6) @(negedge clk);
    chk(irq_n == 1'b1, "R2 irq_n forced high", irq_n, 1);
    repeat (30) @(negedge clk);
    chk(trial_code == 8'h00, "R2 trial held clear", trial_code, 0);
    wr_drv = 1'b1;
    wait_irq(lat);
    chk(lat - 1 >= 66 && lat - 1 <= 73, "R3 latency after long hold", lat - 1, 70);
    read_back(got, oe, irq_a);
    chk(got == 8'hC3, "R2 code after long hold", got, 8'hC3);

    // R6 latch keeps the previous result during the next conversion
    start_conv(8'h0F);
    repeat (30) @(negedge clk);
    chk(data_out == 8'hC3, "R6 previous result held", data_out, 8'hC3);
    wait_irq(lat);
    chk(data_out == 8'h0F, "R6 updated on completion", data_out, 8'h0F);
    read_back(got, oe, irq_a);

    // R8 abort mid conversion
    start_conv(8'h11);
    repeat (30) @(negedge clk);
    chk(irq_n == 1'b1, "R8 no irq before abort", irq_n, 1);
    start_conv(8'hE7);
    wait_irq(lat);
    chk(lat - 1 >= 66 && lat - 1 <= 73, "R8 restart latency", lat - 1, 70);
    read_back(got, oe, irq_a);
    chk(got == 8'hE7, "R8 restarted code", got, 8'hE7);

    // R9 read held across completion
    start_conv(8'h96);
    @(negedge clk); rd_n = 1'b0;
    wait_irq(lat);
    repeat (6) @(negedge clk);
    chk(irq_n == 1'b0, "R9 completion wins over held read", irq_n, 0);
    chk(data_oe == 1'b1 && data_out == 8'h96, "R9 data during held read", data_out, 8'h96);
    rd_n = 1'b1; repeat (4) @(negedge clk);
    rd_n = 1'b0; repeat (5) @(negedge clk);
    chk(irq_n == 1'b1, "R9 new read strobe clears", irq_n, 1);
    rd_n = 1'b1; cs_n = 1'b1; repeat (4) @(negedge clk);

    // R5 every code
    begin
      int bad = 0;
      for (int c = 0; c < 256; c++) begin
        start_conv(c[7:0]);
        wait_irq(lat);
        read_back(got, oe, irq_a);
        if (got != c[7:0]) begin
          bad++;
          $display("FAIL R5 sweep actual=%0h expected=%0h", got, c);
        end
      end
      chk(bad == 0, "R5 all codes", bad, 0);
    end

    // R10 free-running loop
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    vin = 8'h5A; fr = 1'b1; cs_n = 1'b0;
    falls = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (!irq_n) falls++; end
    chk(falls == 0, "R10 no start without pulse", falls, 0);
    wr_drv = 1'b0; repeat (4) @(negedge clk); wr_drv = 1'b1;
    falls = 0;
    begin
      logic prev = 1'b1;
      for (int k = 0; k < 420; k++) begin
        @(negedge clk);
        if (prev && !irq_n) falls++;
        prev = irq_n;
      end
    end
    chk(falls >= 4, "R10 repeated conversions", falls, 5);
    chk(data_out == 8'h5A, "R10 free-run result", data_out, 8'h5A);
    fr = 1'b0; cs_n = 1'b1;
    repeat (4) @(negedge clk);

    if (!wd_hit) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule